// File: doc/BRIEF.md
# Byte-Serial SPI Master with Register Interface

This block is an SPI master that sits on a 32-bit register bus and moves one byte per transfer in both directions at once, over a dedicated serial output and a dedicated serial input. Software picks the clock divider and the clock mode in a configuration word and drives each slave select directly through bits of the control word. Writing the transmit word starts an exchange, and software polls a ready flag before it collects the received byte.

To read a slave without sending anything, software writes zero to the transmit word. A self-clearing flush command empties the receive holding register. Bus reads are registered: read data appears one clock after the address is presented.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the select outputs are all high (inactive), the serial clock is low, the control word reads 0x0000_0002 (ready set), and the configuration and receive words read 0.
- R2: Word offsets are 0x0 control, 0x4 configuration, 0x8 transmit, 0xC receive. Read data is registered one clock after the address. Configuration bits [4:0] (divider), 6 (phase) and 7 (polarity) read back as written. Bits 5 and 17 always read 0 because the block runs only in one-byte, non-queued mode.
- R3: Control bit 16+n drives select output n low while it is 1 and high while it is 0, and reads back as written.
- R4: A transmit write while idle starts a transfer. Control bit 1 (ready) reads 0 from the next clock. It returns to 1 after the eighth input bit has been sampled, 16×H clocks after the write, where H = floor(max(D,2)/2) and D is the divider field.
- R5: Divider values 0 and 1 give the fastest clock, divide-by-2 (H = 1).
- R6: While idle, the serial clock rests at the polarity bit (bit 7): low for 0, high for 1.
- R7: With phase 0, the MSB is on the data output before the first clock edge, input is sampled on leading edges and output changes on trailing edges. With phase 1, output changes on leading edges and input is sampled on trailing edges.
- R8: Data moves MSB first in both directions. The received byte appears in bits [7:0] of the receive word, with the upper bits 0, and stays unchanged while a transfer runs.
- R9: A transmit write during a transfer is ignored. The byte on the wire and the transfer length are unchanged, and no second transfer follows.
- R10: Writing 1 to configuration bit 9 clears the receive word. Bit 9 reads 1 for one clock and then returns to 0 by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |
| spi_cs_n | output | NUM_CS | Active-low slave selects |

## Verification
On every cycle, the properties check that a start raises busy, that the idle serial clock follows the polarity setting, that the flush bit lasts one cycle and empties the receive word, and that the receive word holds still during a transfer. Bit order, the choice of sampling edge in each phase mode, exact transfer length per divider setting, rejection of writes while busy, and select and readback behaviour need the bench's slave model and directed scenarios.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int REG_W         = 32;
  localparam int CTRL_RDY_BIT  = 1;
  localparam int CTRL_CS_LSB   = 16;
  localparam int CFG_PHA_BIT   = 6;
  localparam int CFG_POL_BIT   = 7;
  localparam int CFG_FLUSH_BIT = 9;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;
endpackage

// File: rtl/spi_byte_regs.sv
module spi_byte_regs
  import spi_byte_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_CS  = 4,
  parameter int PRESC_W = 5,
  parameter int BITS    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic               busy,
  input  logic [BITS-1:0]    rx_byte,
  output logic [REG_W-1:0]   rdata,
  output logic [NUM_CS-1:0]  cs_n,
  output logic [PRESC_W-1:0] presc,
  output spi_mode_t          mode,
  output logic               flush,
  output logic               start,
  output logic [BITS-1:0]    tx_byte
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(4'hC);

  logic [NUM_CS-1:0] cs_en;
  logic [REG_W-1:0]  rd_next;
  logic              wr_ctrl, wr_cfg, wr_tx;
  logic              unused_wbits;

  assign unused_wbits = ^wdata;
  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_cfg  = wr && (addr == A_CFG);
  assign wr_tx   = wr && (addr == A_TX);
  assign start   = wr_tx && !busy;
  assign tx_byte = wdata[BITS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_en <= '0;
      cs_n  <= '1;
      presc <= '0;
      mode  <= '0;
      flush <= 1'b0;
    end else begin
      flush <= 1'b0;
      if (wr_ctrl) begin
        cs_en <= wdata[CTRL_CS_LSB +: NUM_CS];
        cs_n  <= ~wdata[CTRL_CS_LSB +: NUM_CS];
      end
      if (wr_cfg) begin
        presc     <= wdata[PRESC_W-1:0];
        mode.cpha <= wdata[CFG_PHA_BIT];
        mode.cpol <= wdata[CFG_POL_BIT];
        flush     <= wdata[CFG_FLUSH_BIT];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    unique case (addr)
      A_CTRL: begin
        rd_next[CTRL_CS_LSB +: NUM_CS] = cs_en;
        rd_next[CTRL_RDY_BIT]          = ~busy;
      end
      A_CFG: begin
        rd_next[PRESC_W-1:0]  = presc;
        rd_next[CFG_PHA_BIT]  = mode.cpha;
        rd_next[CFG_POL_BIT]  = mode.cpol;
        rd_next[CFG_FLUSH_BIT] = flush;
      end
      A_RX:    rd_next[BITS-1:0] = rx_byte;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/spi_byte_clkgen.sv
module spi_byte_clkgen #(
  parameter int PRESC_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt;
  logic [PRESC_W-1:0] half_m1;

  always_comb begin
    if (presc < PRESC_W'(2)) half_m1 = '0;
    else                     half_m1 = (presc >> 1) - PRESC_W'(1);
  end

  assign tick = run && (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + PRESC_W'(1);
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_byte_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [BITS-1:0] tx_byte,
  input  spi_mode_t       mode,
  input  logic            tick,
  input  logic            flush,
  input  logic            miso,
  output logic            busy,
  output logic            sck,
  output logic            mosi,
  output logic [BITS-1:0] rx_byte
);
  localparam int EDGES  = 2 * BITS;
  localparam int ECNT_W = $clog2(EDGES);
  localparam logic [ECNT_W-1:0] LAST = ECNT_W'(EDGES - 1);

  logic [ECNT_W-1:0] edge_cnt;
  logic [BITS-1:0]   tx_sr, rx_sr;
  logic              leading, sample_now, shift_now;

  assign leading    = ~edge_cnt[0];
  assign sample_now = mode.cpha ? !leading : leading;
  assign shift_now  = mode.cpha ? (leading && edge_cnt != '0)
                                : (!leading && edge_cnt != LAST);
  assign mosi       = tx_sr[BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sck      <= 1'b0;
      edge_cnt <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_byte  <= '0;
    end else begin
      if (flush) rx_byte <= '0;
      if (!busy) begin
        sck <= mode.cpol;
        if (start) begin
          busy     <= 1'b1;
          tx_sr    <= tx_byte;
          edge_cnt <= '0;
        end
      end else if (tick) begin
        sck      <= ~sck;
        edge_cnt <= edge_cnt + ECNT_W'(1);
        if (sample_now) rx_sr <= {rx_sr[BITS-2:0], miso};
        if (shift_now)  tx_sr <= {tx_sr[BITS-2:0], 1'b0};
        if (edge_cnt == LAST) begin
          busy    <= 1'b0;
          rx_byte <= sample_now ? {rx_sr[BITS-2:0], miso} : rx_sr;
        end
      end
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_CS  = 4,
  parameter int PRESC_W = 5,
  parameter int BITS    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  logic [PRESC_W-1:0] presc_w;
  spi_mode_t          mode_w;
  logic               cpol_w;
  logic               flush_w, start_w, busy_w, tick_w;
  logic [BITS-1:0]    tx_byte_w, rx_byte_w;

  assign cpol_w = mode_w.cpol;

  spi_byte_regs #(
    .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .PRESC_W(PRESC_W), .BITS(BITS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .busy(busy_w), .rx_byte(rx_byte_w), .rdata(bus_rdata), .cs_n(spi_cs_n),
    .presc(presc_w), .mode(mode_w), .flush(flush_w), .start(start_w),
    .tx_byte(tx_byte_w)
  );

  spi_byte_clkgen #(.PRESC_W(PRESC_W)) u_clkgen (
    .clk(clk), .rst(rst), .run(busy_w), .presc(presc_w), .tick(tick_w)
  );

  spi_byte_shifter #(.BITS(BITS)) u_shift (
    .clk(clk), .rst(rst), .start(start_w), .tx_byte(tx_byte_w),
    .mode(mode_w), .tick(tick_w), .flush(flush_w), .miso(spi_miso),
    .busy(busy_w), .sck(spi_sck), .mosi(spi_mosi), .rx_byte(rx_byte_w)
  );
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int BITS = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            flush,
  input logic            sck,
  input logic            cpol,
  input logic [BITS-1:0] rx_byte
);
  p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  p_idle_sck_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (sck == $past(cpol)));

  p_flush_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (flush && !busy) |=> (rx_byte == '0));

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(flush)) |-> $stable(rx_byte));
endmodule

bind spi_byte_master spi_byte_master_chk #(.BITS(BITS)) u_chk (
  .clk(clk), .rst(rst), .start(start_w), .busy(busy_w), .flush(flush_w),
  .sck(spi_sck), .cpol(cpol_w), .rx_byte(rx_byte_w)
);

// File: tb/spi_byte_master_bench.sv
`timescale 1ns/100ps
module spi_byte_master_bench;
  localparam int NCS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [NCS-1:0] spi_cs_n;

  int vec_n = 0;
  int bad_n = 0;

  always #2.5 clk = ~clk;

  spi_byte_master u_spi_byte_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // slave model
  logic [7:0] s_tx, s_rx;
  logic       s_cpol, s_cpha, s_on = 1'b0;
  int         s_idx;

  always @(spi_sck) begin
    if (s_on) begin
      if ((spi_sck != s_cpol) == !s_cpha) s_rx = {s_rx[6:0], spi_mosi};
      else begin
        if (s_idx < 8) spi_miso = s_tx[7 - s_idx];
        s_idx++;
      end
    end
  end

  task automatic slave_prep(input logic [7:0] b, input logic pol, input logic pha);
    s_tx = b; s_rx = '0; s_cpol = pol; s_cpha = pha;
    s_idx = pha ? 0 : 1;
    spi_miso = pha ? 1'b0 : b[7];
    s_on = 1'b1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vec_n++;
    if (got !== exp) begin
      bad_n++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  // poll ready after a transmit write; n = samples until ready seen
  task automatic poll(output int n);
    bus_addr = 4'h0;
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      n++;
      if (n == 1) chk("R4 ready low after start", {31'd0, bus_rdata[1]}, 32'd0);
      if (bus_rdata[1]) break;
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  endtask

  // {divider[4:0], cpol, cpha, tx[7:0], slave[7:0]}
  localparam logic [22:0] VEC [7] = '{
    {5'd4, 1'b0, 1'b0, 8'hA5, 8'h3C},
    {5'd4, 1'b0, 1'b1, 8'h81, 8'h7E},
    {5'd6, 1'b1, 1'b0, 8'h5A, 8'hC3},
    {5'd2, 1'b1, 1'b1, 8'hFF, 8'h00},
    {5'd0, 1'b0, 1'b0, 8'h00, 8'h96},
    {5'd1, 1'b1, 1'b1, 8'h12, 8'hED},
    {5'd7, 1'b0, 1'b1, 8'h6B, 8'h94}
  };

  initial begin
    #500000;
    bad_n++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 cs idle", {28'd0, spi_cs_n}, 32'hF);
    chk("R1 sck low", {31'd0, spi_sck}, 32'd0);
    rd(4'h0, d); chk("R1 ctrl", d, 32'h0000_0002);
    rd(4'h4, d); chk("R1 cfg", d, 32'd0);
    rd(4'hC, d); chk("R1 rx", d, 32'd0);

    // R2 readback, fixed mode bits read 0
    wr(4'h4, 32'h0002_00FF);
    rd(4'h4, d); chk("R2 cfg readback", d, 32'h0000_00DF);

    // R3 selects
    wr(4'h0, 32'h000A_0000);
    @(posedge clk); #1;
    chk("R3 cs pattern", {28'd0, spi_cs_n}, 32'h5);
    rd(4'h0, d); chk("R3 ctrl readback", d, 32'h000A_0002);
    wr(4'h0, 32'h0000_0000);
    @(posedge clk); #1;
    chk("R3 cs released", {28'd0, spi_cs_n}, 32'hF);

    // vector table: R4 R5 R6 R7 R8
    foreach (VEC[i]) begin
      logic [4:0] dv; logic pol, pha; logic [7:0] tx, sb;
      int h;
      {dv, pol, pha, tx, sb} = VEC[i];
      h = (dv < 2) ? 1 : dv / 2;
      wr(4'h4, {24'd0, pol, pha, 1'b0, dv});
      @(posedge clk); #1;
      chk("R6 idle sck level", {31'd0, spi_sck}, {31'd0, pol});
      slave_prep(sb, pol, pha);
      wr(4'h8, {24'hFFFFFF, tx});
      poll(n);
      s_on = 1'b0;
      chk("R4 R5 transfer length", n, 16 * h + 1);
      chk("R7 slave got tx byte MSB first", {24'd0, s_rx}, {24'd0, tx});
      rd(4'hC, d); chk("R8 rx word", d, {24'd0, sb});
      chk("R6 sck back to idle", {31'd0, spi_sck}, {31'd0, pol});
    end

    // R9 write while busy ignored
    wr(4'h4, 32'h0000_0004);
    @(posedge clk); #1;
    slave_prep(8'h33, 1'b0, 1'b0);
    wr(4'h8, 32'h0000_00A5);
    repeat (5) @(posedge clk);
    wr(4'h8, 32'h0000_000F);
    poll(n);
    s_on = 1'b0;
    chk("R9 busy write ignored, wire byte", {24'd0, s_rx}, 32'hA5);
    repeat (3) @(posedge clk);
    rd(4'h0, d); chk("R9 no second transfer", d, 32'h0000_0002);
    rd(4'hC, d); chk("R9 rx from first transfer", d, 32'h33);

    // R10 flush
    wr(4'h4, 32'h0000_0204);
    @(posedge clk); #1;
    chk("R10 flush bit set", {31'd0, bus_rdata[9]}, 32'd1);
    @(posedge clk); #1;
    chk("R10 flush bit cleared", {31'd0, bus_rdata[9]}, 32'd0);
    rd(4'hC, d); chk("R10 rx cleared", d, 32'd0);

    finish_run();
  end
endmodule